// File: doc/BRIEF.md
# Power Domain Controller

This block switches a set of independent core power domains off and on at the request of software. By default it has three domains: bit 0 is the geometry core, bit 1 is the shared L2 cache and bit 2 is the pixel core. Software reaches it through a simple register port that uses 32-bit words at word-aligned offsets. Writes take effect on a clock edge. Reads are combinational from the address.

Each domain has its own sequencer. The sequencer drives a power request line (1 = keep powered). It then waits for the matching acknowledge from the power switch before it reports that the change is done. An optional settle delay, counted in clock cycles, can be added between the acknowledge and the report.

A sleep status word shows which domains are fully asleep. The end of each power-up is latched as a raw interrupt bit. A mask register gates the raw bits into a single interrupt line, and a write-one-to-clear offset acknowledges them. Software that keeps the mask at zero can poll the status word instead.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: After reset every domain is awake and its power request is high. The sleep status (0x08), interrupt mask (0x0C), raw interrupt (0x10), masked interrupt (0x14) and settle delay (0x1C) registers all read 0, and the interrupt output is low.
- R2: Writing a mask to offset 0x04 starts a power-down of each awake domain whose bit is 1. The request of each such domain drops, and its status bit (bit n = domain n, 1 = asleep) becomes 1 once the acknowledge has gone low. Domains whose bit is 0 are not affected.
- R3: Writing a mask to offset 0x00 starts a power-up of each asleep domain whose bit is 1. Its request rises, and its status bit returns to 0 once the acknowledge has gone high.
- R4: A status bit changes exactly D clock edges after the edge at which the sequencer first samples the new acknowledge level, where D is the value held at offset 0x1C. With D = 0 it changes on that same edge.
- R5: The end of a power-up of domain n sets raw interrupt bit n (offset 0x10) on the same edge as its status change. The end of a power-down sets no raw bit.
- R6: Offset 0x14 reads the raw bits ANDed with the mask at 0x0C. The interrupt output is high exactly when that value is nonzero. With a mask of 0 the output stays low while the raw bits still latch.
- R7: Writing a mask to offset 0x18 clears the raw interrupt bits where the mask is 1 and leaves the others set.
- R8: A command is ignored, with no status change and no interrupt, if its domain is already in the requested state or is still in the middle of a transition.
- R9: A write to offset 0x24 with bit 0 set powers up every asleep domain. A write there with bit 0 clear has no effect.
- R10: Reads of offsets 0x00, 0x04, 0x18 and 0x24 return 0. Every offset other than the nine named ones, misaligned offsets included, reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 6 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwr_req_o | output | N_DOM | Power request per domain, 1 = power on |
| pwr_ack_i | input | N_DOM | Power acknowledge per domain, 1 = powered |
| irq_o | output | 1 | Power-up completion interrupt |

## Verification
A command write takes effect on the edge where the strobe is sampled. The bench's acknowledge model is a three-stage register chain, so the sequencer sees the new acknowledge level on the fourth edge after the command. The status bit and any raw interrupt bit therefore change on edge 4 + D. Both change on the same edge, and the interrupt line follows combinationally.

For every command the driver queues two expected snapshots of status and interrupt: one for the edge just before the due edge and one for the due edge itself. The monitor compares each snapshot at the falling edge of its cycle, so a result that comes one cycle early or one cycle late is caught. Register reads, and the checks that an ignored command had no effect, are made only after the queue has drained.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_UP     = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_DOWN   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_MSKD   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_DELAY  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_MASTER = 6'h24;

    typedef enum logic [2:0] {
        DS_AWAKE     = 3'd0,
        DS_GO_DOWN   = 3'd1,
        DS_SETTLE_DN = 3'd2,
        DS_ASLEEP    = 3'd3,
        DS_GO_UP     = 3'd4,
        DS_SETTLE_UP = 3'd5
    } dom_state_e;

endpackage

// File: rtl/pdc_regs.sv
module pdc_regs
    import pdc_pkg::*;
#(
    parameter int N_DOM = 3,
    parameter int DLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_DOM-1:0]  sleep_stat_i,
    input  logic [N_DOM-1:0]  irq_raw_i,
    output logic [N_DOM-1:0]  up_cmd_o,
    output logic [N_DOM-1:0]  dn_cmd_o,
    output logic [N_DOM-1:0]  clr_cmd_o,
    output logic [N_DOM-1:0]  irq_mask_o,
    output logic [DLY_W-1:0]  delay_o
);

    typedef struct packed {
        logic [N_DOM-1:0] mask;
        logic [DLY_W-1:0] delay;
    } regs_t;

    regs_t r_d, r_q;

    logic [N_DOM-1:0] wmask;
    logic             unused_wdata;

    assign wmask        = bus_wdata[N_DOM-1:0];
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        r_d       = r_q;
        up_cmd_o  = '0;
        dn_cmd_o  = '0;
        clr_cmd_o = '0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_UP:     up_cmd_o  = wmask;
                OFS_DOWN:   dn_cmd_o  = wmask;
                OFS_CLR:    clr_cmd_o = wmask;
                OFS_MASK:   r_d.mask  = wmask;
                OFS_DELAY:  r_d.delay = bus_wdata[DLY_W-1:0];
                OFS_MASTER: up_cmd_o  = {N_DOM{bus_wdata[0]}};
                default:    ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STAT:  bus_rdata = 32'(sleep_stat_i);
            OFS_MASK:  bus_rdata = 32'(r_q.mask);
            OFS_RAW:   bus_rdata = 32'(irq_raw_i);
            OFS_MSKD:  bus_rdata = 32'(irq_raw_i & r_q.mask);
            OFS_DELAY: bus_rdata = 32'(r_q.delay);
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq_mask_o = r_q.mask;
    assign delay_o    = r_q.delay;

endmodule

// File: rtl/pdc_domain_fsm.sv
module pdc_domain_fsm
    import pdc_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_cmd_i,
    input  logic             dn_cmd_i,
    input  logic             ack_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             req_o,
    output logic             asleep_o,
    output logic             woke_o
);

    typedef struct packed {
        dom_state_e       state;
        logic [DLY_W-1:0] cnt;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        woke_o = 1'b0;
        case (s_q.state)
            DS_AWAKE: begin
                if (dn_cmd_i) s_d.state = DS_GO_DOWN;
            end
            DS_GO_DOWN: begin
                if (!ack_i) begin
                    if (delay_i == '0) begin
                        s_d.state = DS_ASLEEP;
                    end else begin
                        s_d.state = DS_SETTLE_DN;
                        s_d.cnt   = delay_i - 1'b1;
                    end
                end
            end
            DS_SETTLE_DN: begin
                if (s_q.cnt == '0) s_d.state = DS_ASLEEP;
                else               s_d.cnt   = s_q.cnt - 1'b1;
            end
            DS_ASLEEP: begin
                if (up_cmd_i) s_d.state = DS_GO_UP;
            end
            DS_GO_UP: begin
                if (ack_i) begin
                    if (delay_i == '0) begin
                        s_d.state = DS_AWAKE;
                        woke_o    = 1'b1;
                    end else begin
                        s_d.state = DS_SETTLE_UP;
                        s_d.cnt   = delay_i - 1'b1;
                    end
                end
            end
            DS_SETTLE_UP: begin
                if (s_q.cnt == '0) begin
                    s_d.state = DS_AWAKE;
                    woke_o    = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.state = DS_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= DS_AWAKE;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o    = (s_q.state == DS_AWAKE) || (s_q.state == DS_GO_UP) ||
                      (s_q.state == DS_SETTLE_UP);
    assign asleep_o = (s_q.state == DS_ASLEEP) || (s_q.state == DS_GO_UP) ||
                      (s_q.state == DS_SETTLE_UP);

endmodule

// File: rtl/pdc_irq.sv
module pdc_irq #(
    parameter int N_DOM = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DOM-1:0] woke_i,
    input  logic [N_DOM-1:0] clr_i,
    input  logic [N_DOM-1:0] mask_i,
    output logic [N_DOM-1:0] raw_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [N_DOM-1:0] raw;
    } irq_t;

    irq_t i_d, i_q;

    always_comb begin
        i_d     = i_q;
        i_d.raw = (i_q.raw & ~clr_i) | woke_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign raw_o = i_q.raw;
    assign irq_o = |(i_q.raw & mask_i);

endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
    import pdc_pkg::*;
#(
    parameter int N_DOM = 3,
    parameter int DLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_DOM-1:0]  pwr_req_o,
    input  logic [N_DOM-1:0]  pwr_ack_i,
    output logic              irq_o
);

    logic [N_DOM-1:0] up_cmd;
    logic [N_DOM-1:0] dn_cmd;
    logic [N_DOM-1:0] clr_cmd;
    logic [N_DOM-1:0] irq_mask;
    logic [N_DOM-1:0] irq_raw;
    logic [N_DOM-1:0] sleep_stat;
    logic [N_DOM-1:0] up_done;
    logic [DLY_W-1:0] dly_val;

    pdc_regs #(.N_DOM(N_DOM), .DLY_W(DLY_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .sleep_stat_i (sleep_stat),
        .irq_raw_i    (irq_raw),
        .up_cmd_o     (up_cmd),
        .dn_cmd_o     (dn_cmd),
        .clr_cmd_o    (clr_cmd),
        .irq_mask_o   (irq_mask),
        .delay_o      (dly_val)
    );

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        pdc_domain_fsm #(.DLY_W(DLY_W)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .up_cmd_i (up_cmd[g]),
            .dn_cmd_i (dn_cmd[g]),
            .ack_i    (pwr_ack_i[g]),
            .delay_i  (dly_val),
            .req_o    (pwr_req_o[g]),
            .asleep_o (sleep_stat[g]),
            .woke_o   (up_done[g])
        );
    end

    pdc_irq #(.N_DOM(N_DOM)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .woke_i (up_done),
        .clr_i  (clr_cmd),
        .mask_i (irq_mask),
        .raw_o  (irq_raw),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
    parameter int N_DOM = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DOM-1:0] status,
    input logic [N_DOM-1:0] raw,
    input logic [N_DOM-1:0] mask,
    input logic [N_DOM-1:0] req,
    input logic [N_DOM-1:0] ack,
    input logic             irq
);

    // R6
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '0));

    // R3
    wake_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~status & $past(status) & ~$past(ack)) == '0));

    // R2
    sleep_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & $past(ack)) == '0));

    // R5
    raw_only_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & ~$past(raw) & ~($past(status) & ~status)) == '0));

    // R2
    asleep_req_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & req) == '0));

endmodule

bind pwr_domain_ctrl pdc_checker #(.N_DOM(N_DOM)) u_pdc_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (sleep_stat),
    .raw    (irq_raw),
    .mask   (irq_mask),
    .req    (pwr_req_o),
    .ack    (pwr_ack_i),
    .irq    (irq_o)
);

// File: tb/tb_pwr_domain_ctrl.sv
module tb_pwr_domain_ctrl;
    import pdc_pkg::*;

    localparam int N       = 3;
    localparam int DW      = 8;
    localparam int ACK_LAT = 3;
    localparam int LAT     = ACK_LAT + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = OFS_STAT;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [N-1:0]      req;
    logic [N-1:0]      ack;
    logic              irq;

    always #5 clk = ~clk;

    pwr_domain_ctrl #(.N_DOM(N), .DLY_W(DW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwr_req_o (req),
        .pwr_ack_i (ack),
        .irq_o     (irq)
    );

    // power switch model: acknowledge follows request after ACK_LAT edges
    logic [N-1:0] ack_pipe [ACK_LAT];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ACK_LAT; i++) ack_pipe[i] <= '1;
        end else begin
            ack_pipe[0] <= req;
            for (int i = 1; i < ACK_LAT; i++) ack_pipe[i] <= ack_pipe[i-1];
        end
    end
    assign ack = ack_pipe[ACK_LAT-1];

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int           due;
        logic [N-1:0] stat;
        logic         irq;
        string        tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_err = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, output int k);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        k = cyc;
        bus_wr = 1'b0; bus_addr = OFS_STAT; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_addr = OFS_STAT;
    endtask

    task automatic expect_at(input int due, input logic [N-1:0] st, input logic iq, input string tag);
        exp_t e;
        e.due = due; e.stat = st; e.irq = iq; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic expect_change(input int k, input int d, input logic [N-1:0] st_old,
                                 input logic [N-1:0] st_new, input logic irq_old,
                                 input logic irq_new, input string tag);
        expect_at(k + LAT + d - 1, st_old, irq_old, {tag, " before due"});
        expect_at(k + LAT + d,     st_new, irq_new, {tag, " at due"});
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: compares queued snapshots at the falling edge of their cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0 && sbq[0].due <= cyc) begin
                exp_t e;
                e = sbq.pop_front();
                if (e.due < cyc) begin
                    check({e.tag, " missed"}, 32'(cyc), 32'(e.due));
                end else begin
                    check({e.tag, " status"}, bus_rdata, 32'(e.stat));
                    check({e.tag, " irq"}, 32'(irq), 32'(e.irq));
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        int k;
        int k2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk(OFS_STAT,  0, "R1 status");
        rd_chk(OFS_MASK,  0, "R1 mask");
        rd_chk(OFS_RAW,   0, "R1 raw");
        rd_chk(OFS_MSKD,  0, "R1 masked");
        rd_chk(OFS_DELAY, 0, "R1 delay");
        check("R1 req", 32'(req), 32'h7);
        check("R1 irq", 32'(irq), 0);

        // R10 write-only and unmapped offsets
        rd_chk(OFS_UP,     0, "R10 read up");
        rd_chk(OFS_DOWN,   0, "R10 read down");
        rd_chk(OFS_CLR,    0, "R10 read clear");
        rd_chk(OFS_MASTER, 0, "R10 read master");
        rd_chk(6'h20,      0, "R10 read 0x20");
        rd_chk(6'h28,      0, "R10 read 0x28");
        wr(6'h0D, 32'h7, k);
        wr(6'h20, 32'hFFFF_FFFF, k);
        rd_chk(OFS_MASK,  0, "R10 misaligned write ignored");
        rd_chk(OFS_DELAY, 0, "R10 unmapped write ignored");
        rd_chk(OFS_STAT,  0, "R10 status untouched");

        wr(OFS_MASK, 32'h7, k);
        rd_chk(OFS_MASK, 32'h7, "R6 mask written");

        // R2 R4 power down domains 0 and 2, delay 0
        wr(OFS_DOWN, 32'h5, k);
        expect_change(k, 0, 3'b000, 3'b101, 1'b0, 1'b0, "R2 R4 down 101");
        drain();
        check("R2 req after down", 32'(req), 32'h2);
        rd_chk(OFS_RAW, 0, "R5 no raw on power-down");

        // R8 commands to domains already in the requested state
        wr(OFS_DOWN, 32'h1, k);
        wr(OFS_UP,   32'h2, k);
        repeat (12) @(negedge clk);
        rd_chk(OFS_STAT, 32'h5, "R8 redundant commands ignored");
        check("R8 no irq", 32'(irq), 0);
        rd_chk(OFS_RAW, 0, "R8 no raw");

        // R3 R4 R5 power up domain 2
        wr(OFS_UP, 32'h4, k);
        expect_change(k, 0, 3'b101, 3'b001, 1'b0, 1'b1, "R3 R5 up 100");
        drain();
        check("R3 req after up", 32'(req), 32'h6);
        rd_chk(OFS_RAW,  32'h4, "R5 raw bit 2");
        rd_chk(OFS_MSKD, 32'h4, "R6 masked bit 2");

        // R6 masking
        wr(OFS_MASK, 32'h3, k);
        rd_chk(OFS_MSKD, 0, "R6 masked off");
        check("R6 irq low when masked", 32'(irq), 0);
        rd_chk(OFS_RAW, 32'h4, "R6 raw kept under mask");
        wr(OFS_MASK, 32'h7, k);
        check("R6 irq back", 32'(irq), 1);

        // R7 clear
        wr(OFS_CLR, 32'h3, k);
        rd_chk(OFS_RAW, 32'h4, "R7 clear of other bits keeps bit 2");
        wr(OFS_CLR, 32'h4, k);
        rd_chk(OFS_RAW, 0, "R7 bit 2 cleared");
        check("R7 irq low", 32'(irq), 0);

        // R4 settle delay 5, power down domain 1
        wr(OFS_DELAY, 32'd5, k);
        rd_chk(OFS_DELAY, 32'd5, "R4 delay written");
        wr(OFS_DOWN, 32'h2, k);
        expect_change(k, 5, 3'b001, 3'b011, 1'b0, 1'b0, "R4 delayed down 010");
        drain();

        // R8 up command during a power-down transition is ignored
        wr(OFS_DOWN, 32'h4, k);
        expect_change(k, 5, 3'b011, 3'b111, 1'b0, 1'b0, "R8 down 100 through up");
        wr(OFS_UP, 32'h4, k2);
        drain();
        rd_chk(OFS_RAW, 0, "R8 no raw after ignored up");

        // R9 master power-up
        wr(OFS_DELAY, 32'd0, k);
        wr(OFS_MASTER, 32'h2, k);
        repeat (12) @(negedge clk);
        rd_chk(OFS_STAT, 32'h7, "R9 master bit0 clear ignored");
        wr(OFS_MASTER, 32'h1, k);
        expect_change(k, 0, 3'b111, 3'b000, 1'b0, 1'b1, "R9 master up");
        drain();
        rd_chk(OFS_RAW, 32'h7, "R9 raw all");
        check("R9 req all", 32'(req), 32'h7);

        // R6 mask zero keeps the line low while raw bits stay latched
        wr(OFS_MASK, 32'h0, k);
        check("R6 mask zero irq low", 32'(irq), 0);
        rd_chk(OFS_MSKD, 0, "R6 masked zero");
        rd_chk(OFS_RAW, 32'h7, "R6 raw kept");

        finish_run();
    end

endmodule